// File: doc/BRIEF.md
# Counter-Mode Block Streaming Controller

This block sits between a host and a counter-mode block cipher core. The host talks to it through a small byte-wide command port: a 2-bit operation code, a 16-bit address and an 8-bit data byte. Through this port it programs a buffer base address, a byte length, a 128-bit counter, two 128-bit keys and a key selector. It then writes a start value. Register reads are answered on a registered response byte one cycle after the command.

Once started, the controller works through an external byte-wide memory one 16-byte block at a time. It fetches the 16 bytes of a block and packs them into a 128-bit word. It hands that word to the cipher together with the counter and the selected key, and waits for the cipher to finish, however long that takes. It then writes the 16 result bytes back over the bytes it fetched. Blocks repeat until the programmed length is covered, and the controller then returns to idle. The cipher core is outside this block and is reached over a start/done handshake.

Top module: `ctr_stream_ctrl`

## Requirements
- R1: Operation code 1 is a register read and code 2 is a register write. Codes 0 and 3 change neither any register nor the response byte.
- R2: Only addresses 0xFF00 to 0xFF3F are decoded. A write outside this window changes no register, and a read outside it leaves the response byte unchanged.
- R3: The response byte shows the selected register byte on the cycle after a read command. The offsets are: engine state at 0x00, buffer base at 0x02 (low byte) and 0x03 (high byte), length at 0x04 and 0x05, key selector at 0x06 bit 0, counter at 0x10 to 0x1F, key 0 at 0x20 to 0x2F and key 1 at 0x30 to 0x3F. All multibyte registers are little-endian.
- R4: The start offset 0x01, the unassigned offsets 0x07 to 0x0F and any other unassigned offset read as 0. The state offset cannot be written.
- R5: Writing 0x01 to offset 0x01 while idle moves the engine state from 0 (idle) to 1 (fetch). Any other value written to offset 0x01 does not start the engine.
- R6: Register writes are refused while the state is not 0. Reads are answered in every state, so the state reads back as nonzero while a job runs.
- R7: In state 1 the controller issues 16 reads in ascending order, at base + block offset + byte index. The memory returns the data one cycle after the read strobe.
- R8: In state 2 the controller raises the cipher start for exactly one cycle. The cipher inputs are the counter, key 0 when the selector is 0 (key 1 otherwise), and the block with fetched byte i in bits 8i+7..8i. The controller waits for done with no bound on latency.
- R9: In state 3 the controller writes result byte i back to the address that byte i was fetched from, in ascending order. A read strobe and a write strobe are never active in the same cycle.
- R10: After each block, the processed count and the block offset both advance by 16. The engine returns to state 1 if the processed count before the block plus 16 is below the length, and to state 0 otherwise. A length of 0 still processes one block.
- R11: After reset the state is 0, all registers are 0, and no memory strobe or cipher start is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 2 | Command operation code |
| cmd_addr | input | 16 | Command register address |
| cmd_wdata | input | 8 | Command write byte |
| rsp_data | output | 8 | Registered read response byte |
| mem_addr | output | 16 | External memory byte address |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_data | input | 8 | Memory read byte, valid the cycle after the strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_data | output | 8 | Memory write byte |
| cph_start | output | 1 | One-cycle cipher start pulse |
| cph_ctr | output | 128 | Counter value given to the cipher |
| cph_key | output | 128 | Selected key given to the cipher |
| cph_blk | output | 128 | Fetched block given to the cipher |
| cph_done | input | 1 | Cipher result valid |
| cph_result | input | 128 | Cipher result block |

## Verification
The bench targets the block-count boundary with three lengths. A length of exactly 32 must give two blocks, 40 must give three and 0 must give one. An off-by-one in the continue test would write 16 bytes too many or too few, and the write scoreboard would flag this. The cipher model changes its latency from block to block, so a controller that sampled done too early, or that started the cipher before the last fetched byte had landed, would write back wrong bytes. Writes are attempted while a job runs, with an ignored operation code and with an address outside the window. A design that leaked any of these would read back a changed base address, and a controller that used the wrong key for the selector would corrupt every stored byte.

// File: rtl/ctrs_pkg.sv
package ctrs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_CRYPT = 2'd2,
    ST_STORE = 2'd3
  } ctrs_state_e;

  localparam logic [1:0] OP_RD = 2'd1;
  localparam logic [1:0] OP_WR = 2'd2;

  localparam logic [5:0] OFF_STATE = 6'h00;
  localparam logic [5:0] OFF_GO    = 6'h01;
  localparam logic [5:0] OFF_BASEL = 6'h02;
  localparam logic [5:0] OFF_BASEH = 6'h03;
  localparam logic [5:0] OFF_LENL  = 6'h04;
  localparam logic [5:0] OFF_LENH  = 6'h05;
  localparam logic [5:0] OFF_KSEL  = 6'h06;
endpackage

// File: rtl/ctrs_regs.sv
module ctrs_regs
  import ctrs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W = 16,
  parameter int BLK_BYTES = 16,
  parameter logic [15:0] WIN_BASE = 16'hFF00
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             cmd_op,
  input  logic [15:0]            cmd_addr,
  input  logic [7:0]             cmd_wdata,
  input  ctrs_state_e            state_i,
  output logic [7:0]             rsp_o,
  output logic [ADDR_W-1:0]      base_o,
  output logic [LEN_W-1:0]       len_o,
  output logic [BLK_BYTES*8-1:0] ctr_o,
  output logic [BLK_BYTES*8-1:0] key_o,
  output logic                   go_o
);
  localparam int BLK_W = BLK_BYTES * 8;

  logic [5:0]        off;
  logic              in_win, wr_ok, rd_ok;
  logic [7:0]        rd_byte;
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  len_q;
  logic              ksel_q;
  logic [BLK_W-1:0]  ctr_q, key0_q, key1_q;
  logic [7:0]        rsp_q;

  assign off    = cmd_addr[5:0];
  assign in_win = (cmd_addr[15:6] == WIN_BASE[15:6]);
  assign wr_ok  = (cmd_op == OP_WR) && in_win && (state_i == ST_IDLE);
  assign rd_ok  = (cmd_op == OP_RD) && in_win;
  assign go_o   = wr_ok && (off == OFF_GO) && (cmd_wdata == 8'h01);

  always_comb begin
    rd_byte = 8'h00;
    unique case (off[5:4])
      2'd0: begin
        case (off)
          OFF_STATE: rd_byte = {6'b0, state_i};
          OFF_BASEL: rd_byte = base_q[7:0];
          OFF_BASEH: rd_byte = base_q[15:8];
          OFF_LENL:  rd_byte = len_q[7:0];
          OFF_LENH:  rd_byte = len_q[15:8];
          OFF_KSEL:  rd_byte = {7'b0, ksel_q};
          default:   rd_byte = 8'h00;
        endcase
      end
      2'd1: rd_byte = ctr_q[off[3:0]*8 +: 8];
      2'd2: rd_byte = key0_q[off[3:0]*8 +: 8];
      2'd3: rd_byte = key1_q[off[3:0]*8 +: 8];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      len_q  <= '0;
      ksel_q <= 1'b0;
      ctr_q  <= '0;
      key0_q <= '0;
      key1_q <= '0;
      rsp_q  <= '0;
    end else begin
      if (rd_ok) rsp_q <= rd_byte;
      if (wr_ok) begin
        unique case (off[5:4])
          2'd0: begin
            case (off)
              OFF_BASEL: base_q[7:0]  <= cmd_wdata;
              OFF_BASEH: base_q[15:8] <= cmd_wdata;
              OFF_LENL:  len_q[7:0]   <= cmd_wdata;
              OFF_LENH:  len_q[15:8]  <= cmd_wdata;
              OFF_KSEL:  ksel_q       <= cmd_wdata[0];
              default: ;
            endcase
          end
          2'd1: ctr_q[off[3:0]*8 +: 8]  <= cmd_wdata;
          2'd2: key0_q[off[3:0]*8 +: 8] <= cmd_wdata;
          2'd3: key1_q[off[3:0]*8 +: 8] <= cmd_wdata;
        endcase
      end
    end
  end

  assign rsp_o  = rsp_q;
  assign base_o = base_q;
  assign len_o  = len_q;
  assign ctr_o  = ctr_q;
  assign key_o  = ksel_q ? key1_q : key0_q;

  AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == OP_WR && state_i != ST_IDLE) |=> ($stable(base_q) && $stable(len_q) && $stable(ksel_q) && $stable(ctr_q) && $stable(key0_q) && $stable(key1_q))); // R6
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cmd_op != OP_RD) |=> $stable(rsp_q)); // R1
  AST_OUTSIDE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!in_win) |=> ($stable(base_q) && $stable(len_q) && $stable(ctr_q))); // R2
endmodule

// File: rtl/ctrs_seq.sv
module ctrs_seq
  import ctrs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W = 16,
  parameter int BLK_BYTES = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   go_i,
  input  logic [ADDR_W-1:0]      base_i,
  input  logic [LEN_W-1:0]       len_i,
  output ctrs_state_e            state_o,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic                   mem_rd_en,
  input  logic [7:0]             mem_rd_data,
  output logic                   mem_wr_en,
  output logic [7:0]             mem_wr_data,
  output logic                   cph_start,
  output logic [BLK_BYTES*8-1:0] cph_blk,
  input  logic                   cph_done,
  input  logic [BLK_BYTES*8-1:0] cph_result
);
  localparam int BLK_W = BLK_BYTES * 8;
  localparam int IDX_W = $clog2(BLK_BYTES);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BLK_BYTES - 1);
  localparam logic [LEN_W:0] STEP = (LEN_W+1)'(BLK_BYTES);

  ctrs_state_e       st_q;
  logic [IDX_W-1:0]  idx_q, oidx_q, cidx_q;
  logic              rd_p1_q, launched_q;
  logic [LEN_W-1:0]  done_cnt_q, blk_off_q;
  logic [BLK_W-1:0]  blk_q, res_q;
  logic [ADDR_W-1:0] cur_addr, addr_q;
  logic              rd_q, wr_q, start_q;
  logic [7:0]        wdat_q;
  logic              more;

  assign cur_addr = base_i + ADDR_W'(blk_off_q) + ADDR_W'(idx_q);
  assign more     = (({1'b0, done_cnt_q} + STEP) < {1'b0, len_i});

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      idx_q      <= '0;
      oidx_q     <= '0;
      cidx_q     <= '0;
      rd_p1_q    <= 1'b0;
      launched_q <= 1'b0;
      done_cnt_q <= '0;
      blk_off_q  <= '0;
      blk_q      <= '0;
      res_q      <= '0;
      addr_q     <= '0;
      rd_q       <= 1'b0;
      wr_q       <= 1'b0;
      start_q    <= 1'b0;
      wdat_q     <= '0;
    end else begin
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      start_q <= 1'b0;
      rd_p1_q <= rd_q;
      cidx_q  <= oidx_q;
      if (rd_p1_q) blk_q[cidx_q*8 +: 8] <= mem_rd_data;
      unique case (st_q)
        ST_IDLE: begin
          if (go_i) begin
            st_q       <= ST_LOAD;
            idx_q      <= '0;
            done_cnt_q <= '0;
            blk_off_q  <= '0;
          end
        end
        ST_LOAD: begin
          rd_q   <= 1'b1;
          addr_q <= cur_addr;
          oidx_q <= idx_q;
          idx_q  <= idx_q + 1'b1;
          if (idx_q == IDX_LAST) begin
            st_q       <= ST_CRYPT;
            launched_q <= 1'b0;
          end
        end
        ST_CRYPT: begin
          if (!launched_q && !rd_q && !rd_p1_q) begin
            start_q    <= 1'b1;
            launched_q <= 1'b1;
          end else if (launched_q && cph_done) begin
            res_q <= cph_result;
            st_q  <= ST_STORE;
            idx_q <= '0;
          end
        end
        ST_STORE: begin
          wr_q   <= 1'b1;
          addr_q <= cur_addr;
          wdat_q <= res_q[idx_q*8 +: 8];
          idx_q  <= idx_q + 1'b1;
          if (idx_q == IDX_LAST) begin
            done_cnt_q <= done_cnt_q + LEN_W'(BLK_BYTES);
            blk_off_q  <= blk_off_q + LEN_W'(BLK_BYTES);
            idx_q      <= '0;
            st_q       <= more ? ST_LOAD : ST_IDLE;
          end
        end
      endcase
    end
  end

  assign state_o     = st_q;
  assign mem_addr    = addr_q;
  assign mem_rd_en   = rd_q;
  assign mem_wr_en   = wr_q;
  assign mem_wr_data = wdat_q;
  assign cph_start   = start_q;
  assign cph_blk     = blk_q;

  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(rd_q && wr_q)); // R9
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q); // R8
  AST_START_IN_CRYPT: assert property (@(posedge clk) disable iff (rst)
    start_q |-> (st_q == ST_CRYPT)); // R8
  AST_STORE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_STORE && $past(st_q) == ST_CRYPT) |-> $past(cph_done)); // R8
  AST_WR_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (wr_q && $past(wr_q)) |-> (addr_q == $past(addr_q) + 1'b1)); // R9
  AST_RD_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (rd_q && $past(rd_q)) |-> (addr_q == $past(addr_q) + 1'b1)); // R7
  AST_LEAVE_IDLE_ON_GO: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_LOAD && $past(st_q) == ST_IDLE) |-> $past(go_i)); // R5
endmodule

// File: rtl/ctr_stream_ctrl.sv
module ctr_stream_ctrl
  import ctrs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W = 16,
  parameter int BLK_BYTES = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             cmd_op,
  input  logic [15:0]            cmd_addr,
  input  logic [7:0]             cmd_wdata,
  output logic [7:0]             rsp_data,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic                   mem_rd_en,
  input  logic [7:0]             mem_rd_data,
  output logic                   mem_wr_en,
  output logic [7:0]             mem_wr_data,
  output logic                   cph_start,
  output logic [BLK_BYTES*8-1:0] cph_ctr,
  output logic [BLK_BYTES*8-1:0] cph_key,
  output logic [BLK_BYTES*8-1:0] cph_blk,
  input  logic                   cph_done,
  input  logic [BLK_BYTES*8-1:0] cph_result
);
  ctrs_state_e       state;
  logic              go;
  logic [ADDR_W-1:0] base;
  logic [LEN_W-1:0]  len;

  ctrs_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BLK_BYTES(BLK_BYTES)) u_regs (
    .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .state_i(state), .rsp_o(rsp_data),
    .base_o(base), .len_o(len), .ctr_o(cph_ctr), .key_o(cph_key), .go_o(go)
  );

  ctrs_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BLK_BYTES(BLK_BYTES)) u_seq (
    .clk(clk), .rst(rst), .go_i(go), .base_i(base), .len_i(len),
    .state_o(state), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
    .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en),
    .mem_wr_data(mem_wr_data), .cph_start(cph_start), .cph_blk(cph_blk),
    .cph_done(cph_done), .cph_result(cph_result)
  );

  AST_NO_ACTIVITY_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && $past(state) == ST_IDLE) |-> (!mem_rd_en && !mem_wr_en && !cph_start)); // R11
endmodule

// File: tb/sim_ctr_stream_ctrl.sv
`timescale 1ns/1ps
module sim_ctr_stream_ctrl;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   cmd_op = 2'd0;
  logic [15:0]  cmd_addr = 16'h0;
  logic [7:0]   cmd_wdata = 8'h0;
  logic [7:0]   rsp_data;
  logic [15:0]  mem_addr;
  logic         mem_rd_en, mem_wr_en;
  logic [7:0]   mem_rd_data = 8'h0;
  logic [7:0]   mem_wr_data;
  logic         cph_start;
  logic [127:0] cph_ctr, cph_key, cph_blk;
  logic         cph_done = 1'b0;
  logic [127:0] cres = '0;

  int nchk = 0;
  int nerr = 0;
  int wr_seen = 0;
  int rd_seen = 0;

  always #2 clk = ~clk;

  ctr_stream_ctrl u0 (
    .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .rsp_data(rsp_data), .mem_addr(mem_addr),
    .mem_rd_en(mem_rd_en), .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en),
    .mem_wr_data(mem_wr_data), .cph_start(cph_start), .cph_ctr(cph_ctr),
    .cph_key(cph_key), .cph_blk(cph_blk), .cph_done(cph_done),
    .cph_result(cres)
  );

  // external memory model: synchronous read, one cycle latency
  logic [7:0] mem [0:1023];
  logic [7:0] ref_mem [0:1023];
  always @(posedge clk) begin
    if (mem_wr_en) mem[mem_addr[9:0]] <= mem_wr_data;
    if (mem_rd_en) mem_rd_data <= mem[mem_addr[9:0]];
  end

  // cipher stand-in with latency that varies from block to block
  logic cbusy = 1'b0;
  int   lat_cnt = 0;
  int   lat_sel = 0;
  always @(posedge clk) begin
    cph_done <= 1'b0;
    if (rst) cbusy <= 1'b0;
    else if (cph_start) begin
      cres    <= cph_blk ^ cph_ctr ^ cph_key;
      cbusy   <= 1'b1;
      lat_cnt <= 1 + (lat_sel % 5);
      lat_sel <= lat_sel + 1;
    end else if (cbusy) begin
      if (lat_cnt == 1) begin cph_done <= 1'b1; cbusy <= 1'b0; end
      else lat_cnt <= lat_cnt - 1;
    end
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard: expected {addr,data} of each write-back
  logic [23:0] exp_q[$];
  always @(negedge clk) begin
    if (!rst && mem_rd_en) rd_seen++;
    if (!rst && mem_wr_en) begin
      wr_seen++;
      if (exp_q.size() == 0) chk("R9 unexpected write", {mem_addr, mem_wr_data}, 24'h0);
      else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        chk("R8 R9 write-back addr/data", {mem_addr, mem_wr_data}, e);
      end
    end
  end

  task automatic cmd(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_op = 2'd0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    cmd(2'd2, a, d);
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v);
    cmd(2'd1, a, 8'h00);
    v = rsp_data;
  endtask

  task automatic prog(input logic [15:0] base, input logic [15:0] len, input logic [127:0] ctr,
                      input logic [127:0] k0, input logic [127:0] k1, input logic ks);
    wr(16'hFF02, base[7:0]); wr(16'hFF03, base[15:8]);
    wr(16'hFF04, len[7:0]);  wr(16'hFF05, len[15:8]);
    wr(16'hFF06, {7'b0, ks});
    for (int i = 0; i < 16; i++) begin
      wr(16'hFF10 + 16'(i), ctr[i*8 +: 8]);
      wr(16'hFF20 + 16'(i), k0[i*8 +: 8]);
      wr(16'hFF30 + 16'(i), k1[i*8 +: 8]);
    end
  endtask

  // driver: push expected results, start, wait for idle, check counts
  task automatic run_job(input string tag, input logic [15:0] base, input logic [15:0] len,
                         input logic [127:0] ctr, input logic [127:0] key, input bit poke_busy);
    int nb;
    int w0, r0;
    logic [7:0] v;
    nb = 1;
    while (16 * nb < int'(len)) nb++;
    for (int b = 0; b < nb; b++)
      for (int i = 0; i < 16; i++) begin
        logic [15:0] a;
        logic [7:0]  d;
        a = base + 16'(16 * b + i);
        d = ref_mem[a[9:0]] ^ ctr[i*8 +: 8] ^ key[i*8 +: 8];
        ref_mem[a[9:0]] = d;
        exp_q.push_back({a, d});
      end
    w0 = wr_seen; r0 = rd_seen;
    wr(16'hFF01, 8'h01);
    rd(16'hFF00, v);
    chk({tag, " R5 R6 state after start"}, v, 8'h01);
    if (poke_busy) wr(16'hFF02, 8'hEE);
    for (int k = 0; k < 3000; k++) begin
      rd(16'hFF00, v);
      if (v == 8'h00) break;
    end
    repeat (4) @(negedge clk);
    chk({tag, " R10 idle at end"}, v, 8'h00);
    chk({tag, " R10 write count"}, wr_seen - w0, nb * 16);
    chk({tag, " R7 read count"}, rd_seen - r0, nb * 16);
    chk({tag, " R9 scoreboard drained"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [127:0] ctr_a, k0_a, k1_a;
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 8'(i * 7 + 3);
      ref_mem[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 rsp after reset", rsp_data, 8'h00);
    chk("R11 strobes after reset", {mem_rd_en, mem_wr_en, cph_start}, 3'b000);
    rd(16'hFF00, v); chk("R11 state after reset", v, 8'h00);
    rd(16'hFF04, v); chk("R11 length after reset", v, 8'h00);

    ctr_a = 128'h0F0E0D0C0B0A09080706050403020100;
    k0_a  = 128'hA5A5A5A55A5A5A5A1234567890ABCDEF;
    k1_a  = 128'h3C3C3C3CC3C3C3C3FEDCBA0987654321;
    prog(16'h0100, 16'd16, ctr_a, k0_a, k1_a, 1'b0);
    rd(16'hFF02, v); chk("R3 base low", v, 8'h00);
    rd(16'hFF03, v); chk("R3 base high", v, 8'h01);
    rd(16'hFF04, v); chk("R3 length low", v, 8'h10);
    rd(16'hFF15, v); chk("R3 counter byte 5", v, 8'h05);
    rd(16'hFF20, v); chk("R3 key0 byte 0", v, 8'hEF);
    rd(16'hFF3F, v); chk("R3 key1 byte 15", v, 8'h3C);
    rd(16'hFF06, v); chk("R3 key select", v, 8'h00);

    rd(16'hFF08, v); chk("R4 unassigned offset", v, 8'h00);
    rd(16'hFF01, v); chk("R4 start offset reads 0", v, 8'h00);
    wr(16'hFF00, 8'h03);
    rd(16'hFF00, v); chk("R4 state not writable", v, 8'h00);

    cmd(2'd3, 16'hFF02, 8'h55);
    rd(16'hFF02, v); chk("R1 op 3 ignored", v, 8'h00);
    rd(16'hFF04, v);
    cmd(2'd0, 16'hFF02, 8'h00);
    chk("R1 op 0 leaves response", rsp_data, 8'h10);

    wr(16'hFE02, 8'h77);
    rd(16'hFF02, v); chk("R2 write outside window", v, 8'h00);
    cmd(2'd1, 16'hFE00, 8'h00);
    chk("R2 read outside window holds", rsp_data, 8'h00);

    wr(16'hFF01, 8'h02);
    rd(16'hFF00, v); chk("R5 wrong start value", v, 8'h00);

    run_job("jobA len16 key0", 16'h0100, 16'd16, ctr_a, k0_a, 1'b0);

    prog(16'h0200, 16'd40, ctr_a ^ 128'h1, k0_a, k1_a, 1'b1);
    run_job("jobB len40 key1", 16'h0200, 16'd40, ctr_a ^ 128'h1, k1_a, 1'b1);
    rd(16'hFF02, v); chk("R6 busy write refused", v, 8'h00);

    wr(16'hFF04, 8'h00);
    run_job("jobC len0", 16'h0200, 16'd0, ctr_a ^ 128'h1, k1_a, 1'b0);

    wr(16'hFF02, 8'h80); wr(16'hFF03, 8'h02); wr(16'hFF04, 8'h20); wr(16'hFF06, 8'h00);
    run_job("jobD len32", 16'h0280, 16'd32, ctr_a ^ 128'h1, k0_a, 1'b0);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule